// File: doc/BRIEF.md
# Compressed Instruction Fetch Realigner

This block sits between an aligned 32-bit instruction fetch path and the instruction decoder of a core that mixes 16-bit compressed and 32-bit full-length instructions. It accepts one fetch word per handshake and holds the address of the instruction it is building. From each word it takes the lower half, the upper half or the whole word, depending on bit 1 of that address. When a full-length instruction starts in the upper half of one word, the block keeps that half and completes the instruction from the lower half of the next word.

A completed instruction is offered to the decoder with a valid/ready handshake. It comes with its own address, its length, the next sequential address and an illegal-encoding flag for a few reserved compressed forms. The block publishes the word-aligned address of the fetch word it needs next. It refuses new fetch words while it holds a completed instruction. A redirect or a pipeline flush throws away any partial or held instruction.

Top module: `rvc_fetch_realign`

## Requirements
- R1: After reset, `instr_valid` is 0, `fetch_ready` is 1, `instr_bits` holds the no-op value 0x00000013 and `fetch_addr` equals the reset address rounded down to a multiple of 4.
- R2: A 16-bit parcel counts as compressed when its bits [1:0] are anything other than 2'b11. A parcel with 2'b11 there starts a 32-bit instruction. `instr_short` reports which case applies.
- R3: At an address with bit 1 clear, a compressed lower half is presented the cycle after the fetch handshake as {16'h0000, word[15:0]}, with `instr_next_pc` = address + 2.
- R4: At an address with bit 1 clear, a full-length lower half is presented the cycle after the fetch handshake as the whole word, with `instr_next_pc` = address + 4.
- R5: At an address with bit 1 set, a compressed upper half is presented the cycle after the handshake as {16'h0000, word[31:16]}, with `instr_next_pc` = address + 2.
- R6: At an address with bit 1 set, a full-length upper half produces no output. `fetch_ready` stays 1 and `fetch_addr` moves to the following word. The next accepted word supplies bits [31:16] of the instruction from its lower half, and the instruction is presented the cycle after that handshake with `instr_next_pc` = address + 4.
- R7: While `instr_valid` is 1 and `instr_ready` is 0, `fetch_ready` is 0 and the presented instruction, address and flags stay unchanged.
- R8: When `instr_valid` and `instr_ready` are both 1 at a clock edge, the instruction address becomes `instr_next_pc` and `instr_valid` is 0 in the next cycle.
- R9: A redirect takes priority over everything else. It forces `fetch_ready` to 0 during that cycle and discards any partial or held instruction. It restarts assembly at `redirect_pc` with bit 0 cleared.
- R10: A flush discards any partial or held instruction, keeps the current instruction address and reloads the no-op value into `instr_bits`.
- R11: A compressed instruction of all zeros is flagged illegal.
- R12: A compressed parcel with bits [1:0] = 01 and bits [15:13] = 000 is flagged illegal when exactly one of these holds: the register field in bits [11:7] is zero, or the immediate {bit 12, bits [6:2]} is zero. When both are zero or both are nonzero the parcel is legal.
- R13: A full-length instruction is never flagged illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| redirect_valid | input | 1 | Restart assembly at a new address |
| redirect_pc | input | XLEN | Target of the redirect |
| flush | input | 1 | Discard partial or held instruction, keep address |
| fetch_valid | input | 1 | A fetch word is offered |
| fetch_word | input | 32 | Aligned fetch word |
| fetch_ready | output | 1 | Block will take a fetch word this cycle |
| fetch_addr | output | XLEN | Word-aligned address of the word needed next |
| instr_valid | output | 1 | A completed instruction is presented |
| instr_ready | input | 1 | Decoder takes the presented instruction |
| instr_bits | output | 32 | Completed instruction, compressed ones zero-extended |
| instr_pc | output | XLEN | Address of the presented instruction |
| instr_next_pc | output | XLEN | Next sequential address |
| instr_short | output | 1 | Presented instruction is 16 bits long |
| instr_illegal | output | 1 | Presented instruction is a reserved compressed form |

## Verification
The assertions assume that the fetch side delivers the word at `fetch_addr` whenever it asserts `fetch_valid`. They also assume that redirect and flush are one-cycle pulses that do not coincide with reset. The stimulus always supplies a word that matches the address the current test places at the block, and it changes inputs only half a period after a clock edge. Redirect and flush are pulsed for exactly one cycle. The decoder side is stalled only on purpose, to exercise the hold behaviour, and is released before the next instruction is expected.

// File: rtl/rvc_realign_pkg.sv
package rvc_realign_pkg;

    localparam int PARCEL_W = 16;
    localparam int WORD_W   = 32;
    localparam logic [WORD_W-1:0] NOP_WORD = 32'h0000_0013;

    typedef logic [PARCEL_W-1:0] parcel_t;

    // Assembly progress of the instruction being built
    typedef enum logic [1:0] {
        SLOT_IDLE = 2'd0,   // collecting, nothing partial
        SLOT_MID  = 2'd1,   // low parcel of a full instruction held
        SLOT_FULL = 2'd2    // completed instruction presented
    } slot_e;

    typedef struct packed {
        logic [WORD_W-1:0] bits;
        logic              short_len;
    } held_t;

    function automatic logic is_short(input parcel_t p);
        return p[1:0] != 2'b11;
    endfunction

    // Reserved compressed encodings this block reports
    function automatic logic parcel_reserved(input parcel_t p);
        logic addi_form;
        logic rd_zero;
        logic imm_zero;
        addi_form = (p[1:0] == 2'b01) && (p[15:13] == 3'b000);
        rd_zero   = (p[11:7] == 5'd0);
        imm_zero  = ({p[12], p[6:2]} == 6'd0);
        return (p == '0) || (addi_form && (rd_zero != imm_zero));
    endfunction

endpackage

// File: rtl/rvc_seq_pc.sv
module rvc_seq_pc #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] pc_i,
    input  logic            short_i,
    output logic [XLEN-1:0] next_pc_o
);
    localparam logic [XLEN-1:0] STEP_SHORT = XLEN'(2);
    localparam logic [XLEN-1:0] STEP_FULL  = XLEN'(4);

    always_comb begin
        next_pc_o = pc_i + (short_i ? STEP_SHORT : STEP_FULL);
    end
endmodule

// File: rtl/rvc_legality.sv
module rvc_legality
    import rvc_realign_pkg::*;
(
    input  held_t inst_i,
    output logic  illegal_o
);
    always_comb begin
        illegal_o = inst_i.short_len && parcel_reserved(inst_i.bits[PARCEL_W-1:0]);
    end
endmodule

// File: rtl/rvc_realign_core.sv
module rvc_realign_core
    import rvc_realign_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            redirect_i,
    input  logic [XLEN-1:0] redirect_pc_i,
    input  logic            flush_i,
    input  logic            fetch_valid_i,
    input  logic [31:0]     fetch_word_i,
    output logic            fetch_ready_o,
    output logic [XLEN-1:0] fetch_addr_o,
    input  logic            take_i,
    input  logic [XLEN-1:0] next_pc_i,
    output slot_e           state_o,
    output held_t           inst_o,
    output logic [XLEN-1:0] pc_o
);
    localparam int              WIDX      = XLEN - 2;
    localparam logic [XLEN-1:0] HALF_MASK = ~XLEN'(1);

    slot_e           state_q;
    held_t           inst_q;
    logic [XLEN-1:0] pc_q;
    parcel_t         lo_half;
    parcel_t         hi_half;
    logic            fetch_fire;
    logic            accept;

    assign lo_half = fetch_word_i[PARCEL_W-1:0];
    assign hi_half = fetch_word_i[WORD_W-1:PARCEL_W];

    always_comb begin
        fetch_ready_o = (state_q != SLOT_FULL) && !redirect_i && !flush_i;
        fetch_fire    = fetch_valid_i && fetch_ready_o;
        accept        = (state_q == SLOT_FULL) && take_i;
        fetch_addr_o  = {pc_q[XLEN-1:2] + WIDX'(state_q == SLOT_MID), 2'b00};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SLOT_IDLE;
            pc_q    <= RESET_PC & HALF_MASK;
            inst_q  <= '{bits: NOP_WORD, short_len: 1'b0};
        end else if (redirect_i) begin
            state_q <= SLOT_IDLE;
            pc_q    <= redirect_pc_i & HALF_MASK;
            inst_q  <= '{bits: NOP_WORD, short_len: 1'b0};
        end else if (flush_i) begin
            state_q <= SLOT_IDLE;
            inst_q  <= '{bits: NOP_WORD, short_len: 1'b0};
        end else if (accept) begin
            state_q <= SLOT_IDLE;
            pc_q    <= next_pc_i;
            inst_q  <= '{bits: NOP_WORD, short_len: 1'b0};
        end else if (fetch_fire) begin
            unique case (state_q)
                SLOT_IDLE: begin
                    if (!pc_q[1]) begin
                        state_q <= SLOT_FULL;
                        if (is_short(lo_half)) begin
                            inst_q <= '{bits: {16'h0000, lo_half}, short_len: 1'b1};
                        end else begin
                            inst_q <= '{bits: fetch_word_i, short_len: 1'b0};
                        end
                    end else begin
                        inst_q <= '{bits: {16'h0000, hi_half}, short_len: is_short(hi_half)};
                        state_q <= is_short(hi_half) ? SLOT_FULL : SLOT_MID;
                    end
                end
                SLOT_MID: begin
                    inst_q.bits[WORD_W-1:PARCEL_W] <= lo_half;
                    state_q <= SLOT_FULL;
                end
                default: state_q <= state_q;
            endcase
        end
    end

    assign state_o = state_q;
    assign inst_o  = inst_q;
    assign pc_o    = pc_q;

    // R6
    mid_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == SLOT_MID) |-> (inst_q.bits[WORD_W-1:PARCEL_W] == '0 && !inst_q.short_len));

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == SLOT_FULL && !take_i && !redirect_i && !flush_i)
        |=> (state_q == SLOT_FULL && $stable(inst_q) && $stable(pc_q)));

    // R8
    accept_pc_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && !redirect_i && !flush_i)
        |=> (state_q == SLOT_IDLE && pc_q == $past(next_pc_i)));

    // R9
    redirect_clear_chk: assert property (@(posedge clk) disable iff (rst)
        redirect_i |=> (state_q == SLOT_IDLE && pc_q[0] == 1'b0));

    // R10
    flush_keep_pc_chk: assert property (@(posedge clk) disable iff (rst)
        (flush_i && !redirect_i) |=> (state_q == SLOT_IDLE && $stable(pc_q)));
endmodule

// File: rtl/rvc_fetch_realign.sv
module rvc_fetch_realign
    import rvc_realign_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            redirect_valid,
    input  logic [XLEN-1:0] redirect_pc,
    input  logic            flush,
    input  logic            fetch_valid,
    input  logic [31:0]     fetch_word,
    output logic            fetch_ready,
    output logic [XLEN-1:0] fetch_addr,
    output logic            instr_valid,
    input  logic            instr_ready,
    output logic [31:0]     instr_bits,
    output logic [XLEN-1:0] instr_pc,
    output logic [XLEN-1:0] instr_next_pc,
    output logic            instr_short,
    output logic            instr_illegal
);
    slot_e           state;
    held_t           inst;
    logic [XLEN-1:0] cur_pc;
    logic [XLEN-1:0] seq_pc;
    logic            illegal;

    rvc_realign_core #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_core (
        .clk           (clk),
        .rst           (rst),
        .redirect_i    (redirect_valid),
        .redirect_pc_i (redirect_pc),
        .flush_i       (flush),
        .fetch_valid_i (fetch_valid),
        .fetch_word_i  (fetch_word),
        .fetch_ready_o (fetch_ready),
        .fetch_addr_o  (fetch_addr),
        .take_i        (instr_ready),
        .next_pc_i     (seq_pc),
        .state_o       (state),
        .inst_o        (inst),
        .pc_o          (cur_pc)
    );

    rvc_seq_pc #(.XLEN(XLEN)) u_seq (
        .pc_i      (cur_pc),
        .short_i   (inst.short_len),
        .next_pc_o (seq_pc)
    );

    rvc_legality u_legal (
        .inst_i    (inst),
        .illegal_o (illegal)
    );

    assign instr_valid   = (state == SLOT_FULL);
    assign instr_bits    = inst.bits;
    assign instr_pc      = cur_pc;
    assign instr_next_pc = seq_pc;
    assign instr_short   = inst.short_len;
    assign instr_illegal = illegal;

    // R13
    full_legal_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && instr_bits[1:0] == 2'b11) |-> !instr_illegal);

    // R7
    no_fetch_while_full_chk: assert property (@(posedge clk) disable iff (rst)
        instr_valid |-> !fetch_ready);

    // R2
    short_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && instr_short) |-> (instr_bits[31:16] == 16'h0000 && instr_bits[1:0] != 2'b11));
endmodule

// File: tb/test_rvc_fetch_realign.sv
module test_rvc_fetch_realign;
    localparam int XLEN       = 32;
    localparam int CLK_PERIOD = 10;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            redirect_valid = 1'b0;
    logic [XLEN-1:0] redirect_pc = '0;
    logic            flush = 1'b0;
    logic            fetch_valid = 1'b0;
    logic [31:0]     fetch_word = '0;
    logic            fetch_ready;
    logic [XLEN-1:0] fetch_addr;
    logic            instr_valid;
    logic            instr_ready = 1'b1;
    logic [31:0]     instr_bits;
    logic [XLEN-1:0] instr_pc;
    logic [XLEN-1:0] instr_next_pc;
    logic            instr_short;
    logic            instr_illegal;

    always #(CLK_PERIOD/2) clk = ~clk;

    rvc_fetch_realign #(.XLEN(XLEN), .RESET_PC('0)) i_rvc_fetch_realign (
        .clk(clk), .rst(rst),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .flush(flush),
        .fetch_valid(fetch_valid), .fetch_word(fetch_word),
        .fetch_ready(fetch_ready), .fetch_addr(fetch_addr),
        .instr_valid(instr_valid), .instr_ready(instr_ready),
        .instr_bits(instr_bits), .instr_pc(instr_pc), .instr_next_pc(instr_next_pc),
        .instr_short(instr_short), .instr_illegal(instr_illegal)
    );

    typedef struct {
        logic [31:0]     bits;
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] npc;
        logic            ill;
        string           req;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic expect_instr(input logic [31:0] bits, input logic [XLEN-1:0] pc,
                                input logic [XLEN-1:0] npc, input logic ill, input string req);
        exp_t e;
        e.bits = bits; e.pc = pc; e.npc = npc; e.ill = ill; e.req = req;
        exp_q.push_back(e);
    endtask

    // Driver: offer one fetch word and hold it until taken
    task automatic feed(input logic [31:0] w);
        @(negedge clk);
        fetch_word  = w;
        fetch_valid = 1'b1;
        #1;
        while (!fetch_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        fetch_valid = 1'b0;
    endtask

    task automatic pulse_redirect(input logic [XLEN-1:0] target);
        @(negedge clk);
        redirect_valid = 1'b1;
        redirect_pc    = target;
        #1;
        chk(fetch_ready == 1'b0, "R9 ready low during redirect", 32'(fetch_ready), 32'h0);
        @(negedge clk);
        redirect_valid = 1'b0;
    endtask

    task automatic pulse_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 20; i++) begin
            if (exp_q.size() == 0 && !instr_valid) break;
            @(negedge clk);
            #3;
        end
        chk(exp_q.size() == 0, "R8 all expected instructions seen", 32'(exp_q.size()), 32'h0);
    endtask

    // Monitor: compare each accepted instruction with the scoreboard
    always @(negedge clk) begin
        #2;
        if (!rst && instr_valid && instr_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8 unexpected instruction", instr_bits, 32'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(instr_bits == e.bits, {e.req, " bits"}, instr_bits, e.bits);
                chk(instr_pc == e.pc, {e.req, " pc"}, instr_pc, e.pc);
                chk(instr_next_pc == e.npc, {e.req, " next pc"}, instr_next_pc, e.npc);
                chk(instr_illegal == e.ill, {e.req, " illegal"}, 32'(instr_illegal), 32'(e.ill));
            end
        end
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk(instr_valid == 1'b0, "R1 valid low", 32'(instr_valid), 32'h0);
        chk(fetch_ready == 1'b1, "R1 ready high", 32'(fetch_ready), 32'h1);
        chk(instr_bits == 32'h0000_0013, "R1 no-op loaded", instr_bits, 32'h0000_0013);
        chk(fetch_addr == 32'h0, "R1 fetch address", fetch_addr, 32'h0);

        // R4 R2 aligned full-length
        expect_instr(32'h00A3_0293, 32'h0, 32'h4, 1'b0, "R4");
        feed(32'h00A3_0293);
        drain();
        // R3 R2 aligned compressed, upper half discarded
        expect_instr(32'h0000_4501, 32'h4, 32'h6, 1'b0, "R3");
        feed(32'h1505_4501);
        drain();
        // R5 upper compressed (c.addi with nonzero rd and imm: legal, R12)
        expect_instr(32'h0000_1505, 32'h6, 32'h8, 1'b0, "R5 R12");
        feed(32'h1505_4501);
        drain();
        // R12 rd zero, imm nonzero; upper half zeroed (R3)
        expect_instr(32'h0000_0005, 32'h8, 32'hA, 1'b1, "R12 R3");
        feed(32'hFFFF_0005);
        drain();
        // R6 straddling full-length instruction
        feed(32'h0513_0001);
        #1;
        chk(instr_valid == 1'b0, "R6 no output while partial", 32'(instr_valid), 32'h0);
        chk(fetch_ready == 1'b1, "R6 still requesting", 32'(fetch_ready), 32'h1);
        chk(fetch_addr == 32'hC, "R6 next word address", fetch_addr, 32'hC);
        expect_instr(32'h0085_0513, 32'hA, 32'hE, 1'b0, "R6");
        feed(32'h1234_0085);
        drain();
        // R11 all-zero compressed
        expect_instr(32'h0000_0000, 32'hE, 32'h10, 1'b1, "R11");
        feed(32'h0000_1234);
        drain();
        // R12 nonzero rd with zero imm, then c.nop legal
        expect_instr(32'h0000_0501, 32'h10, 32'h12, 1'b1, "R12 zero imm");
        feed(32'h0001_0501);
        drain();
        expect_instr(32'h0000_0001, 32'h12, 32'h14, 1'b0, "R12 nop legal");
        feed(32'h0001_0501);
        drain();
        // R13 full-length never flagged
        expect_instr(32'h0000_0003, 32'h14, 32'h18, 1'b0, "R13");
        feed(32'h0000_0003);
        drain();

        // R7 stall holds output and blocks fetch
        instr_ready = 1'b0;
        expect_instr(32'h0041_0113, 32'h18, 32'h1C, 1'b0, "R7");
        feed(32'h0041_0113);
        repeat (3) @(negedge clk);
        #1;
        chk(instr_valid == 1'b1, "R7 held valid", 32'(instr_valid), 32'h1);
        chk(fetch_ready == 1'b0, "R7 fetch blocked", 32'(fetch_ready), 32'h0);
        chk(instr_bits == 32'h0041_0113, "R7 held bits", instr_bits, 32'h0041_0113);
        instr_ready = 1'b1;
        drain();

        // R9 redirect discards a partial instruction; bit 0 ignored
        pulse_redirect(32'h22);
        feed(32'h0613_0000);
        #1;
        chk(fetch_addr == 32'h24, "R6 mid address after redirect", fetch_addr, 32'h24);
        pulse_redirect(32'h43);
        #1;
        chk(instr_valid == 1'b0, "R9 nothing presented", 32'(instr_valid), 32'h0);
        chk(fetch_addr == 32'h40, "R9 restart address", fetch_addr, 32'h40);
        chk(fetch_ready == 1'b1, "R9 requesting after redirect", 32'(fetch_ready), 32'h1);
        expect_instr(32'h0000_4501, 32'h42, 32'h44, 1'b0, "R9");
        feed(32'h4501_FFFF);
        drain();

        // R10 flush discards partial, keeps address
        pulse_redirect(32'h46);
        feed(32'h0713_0000);
        pulse_flush();
        #1;
        chk(fetch_addr == 32'h44, "R10 address kept", fetch_addr, 32'h44);
        chk(instr_valid == 1'b0, "R10 nothing presented", 32'(instr_valid), 32'h0);
        expect_instr(32'h0000_4505, 32'h46, 32'h48, 1'b0, "R10 R5");
        feed(32'h4505_0000);
        drain();

        // R10 flush discards a held instruction
        instr_ready = 1'b0;
        feed(32'h0000_0093);
        pulse_flush();
        #1;
        chk(instr_valid == 1'b0, "R10 held dropped", 32'(instr_valid), 32'h0);
        chk(instr_bits == 32'h0000_0013, "R10 no-op reloaded", instr_bits, 32'h0000_0013);
        chk(fetch_addr == 32'h48, "R10 address kept after hold", fetch_addr, 32'h48);
        instr_ready = 1'b1;
        expect_instr(32'h0000_0013, 32'h48, 32'h4C, 1'b0, "R10 R4");
        feed(32'h0000_0013);
        drain();

        done = 1'b1;
        summary();
        $finish;
    end
endmodule